// File: doc/BRIEF.md
# Sequential RGB Colour Lookup Table

This block holds a colour lookup table of 256 main pixel entries plus 4 overlay entries used for a hardware cursor, each entry a 24-bit red, green and blue value. Software reaches the table through a small 32-bit register window. It first loads an entry pointer. It then moves colour bytes through a single data register, one component per access, always in red, green, blue order. After each complete triplet the pointer steps to the next entry. Two data offsets share the pointer: one reaches the main table, the other reaches the overlay sub-table through the low pointer bits.

A second, independent port serves a pixel pipeline. It takes an entry number covering both tables and returns that entry's RGB value combinationally. A register write changes the table on the clock edge, so the new colour appears on the lookup port one cycle later.

Top module: `clut_regs`

## Requirements
- R1: A write at byte offset 0x0 loads the entry pointer from write-data bits 31:24 and returns the component step to red, including in the middle of a triplet.
- R2: Writes at offset 0x4 store into main entry `pointer`. Bits 31:24 of the first write go to red, the second to green and the third to blue.
- R3: After the blue access the step returns to red and the pointer increments modulo 256 (255 goes to 0). The step never takes a fourth value.
- R4: Writes at offset 0xC store, in the same order, into overlay entry 256 + pointer[1:0]. The pointer still increments after blue.
- R5: A read at offset 0x4 or 0xC returns the current component of the selected entry in bits 31:24, with bits 23:0 zero, and advances the step and pointer exactly like a write.
- R6: Reads and writes share one step counter and one pointer, so mixed accesses continue the same red/green/blue sequence.
- R7: A write to any other offset in the 16-byte window changes no entry, pointer or step. A read there returns zero and advances nothing.
- R8: After reset every entry is black (0x000000) except entries 255, 256 and 258, which are white (0xFFFFFF), and the pointer and step are zero.
- R9: The lookup port returns {red, green, blue} of entry 0..259 combinationally. An entry written by the register port shows its new value from the next cycle. Entry numbers above 259 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe (wins over reg_rd) |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset inside the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| lut_idx | input | 9 | Lookup entry number |
| lut_rgb | output | 24 | Lookup result {red, green, blue} |

## Verification
The bench builds the block with its default parameters: 256 main entries, 4 overlay entries and 8-bit components. With these values the pointer wrap from 255 to 0 and all four overlay slots can be reached with a few accesses. The 9-bit lookup number also reaches values above 259, which exercises the out-of-range result. A full sweep of all 260 entries after reset then checks every reset value directly.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int COMP_W = 8;

    typedef enum logic [1:0] {
        STEP_RED   = 2'd0,
        STEP_GREEN = 2'd1,
        STEP_BLUE  = 2'd2
    } step_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] green;
        logic [COMP_W-1:0] blue;
    } rgb_t;

    localparam logic [3:0] OFS_POINTER = 4'h0;
    localparam logic [3:0] OFS_MAIN    = 4'h4;
    localparam logic [3:0] OFS_OVERLAY = 4'hC;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output step_e            comp
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        step_e            comp;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (load) begin
            seq_d.ptr  = load_val;
            seq_d.comp = STEP_RED;
        end else if (step) begin
            case (seq_q.comp)
                STEP_RED:   seq_d.comp = STEP_GREEN;
                STEP_GREEN: seq_d.comp = STEP_BLUE;
                default: begin
                    seq_d.comp = STEP_RED;
                    seq_d.ptr  = seq_q.ptr + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.ptr  <= '0;
            seq_q.comp <= STEP_RED;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ptr  = seq_q.ptr;
    assign comp = seq_q.comp;
endmodule

// File: rtl/clut_table.sv
module clut_table
    import clut_pkg::*;
#(
    parameter int MAIN_N = 256,
    parameter int OVL_N  = 4,
    localparam int TOTAL = MAIN_N + OVL_N,
    localparam int ENT_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ENT_W-1:0]  w_ent,
    input  step_e             w_comp,
    input  logic [COMP_W-1:0] w_byte,
    input  logic [ENT_W-1:0]  r_ent,
    input  step_e             r_comp,
    output logic [COMP_W-1:0] r_byte,
    input  logic [ENT_W-1:0]  lk_ent,
    output rgb_t              lk_rgb
);
    rgb_t mem_d [TOTAL];
    rgb_t mem_q [TOTAL];

    function automatic rgb_t reset_value(input int ent);
        if (ent == MAIN_N - 1 || ent == MAIN_N || ent == MAIN_N + 2)
            return '1;
        return '0;
    endfunction

    always_comb begin
        for (int i = 0; i < TOTAL; i++) mem_d[i] = mem_q[i];
        if (we && int'(w_ent) < TOTAL) begin
            case (w_comp)
                STEP_RED:   mem_d[int'(w_ent)].red   = w_byte;
                STEP_GREEN: mem_d[int'(w_ent)].green = w_byte;
                default:    mem_d[int'(w_ent)].blue  = w_byte;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < TOTAL; i++) begin
            if (!rst_n) mem_q[i] <= reset_value(i);
            else        mem_q[i] <= mem_d[i];
        end
    end

    rgb_t r_sel;
    always_comb begin
        r_sel = (int'(r_ent) < TOTAL) ? mem_q[int'(r_ent)] : '0;
        case (r_comp)
            STEP_RED:   r_byte = r_sel.red;
            STEP_GREEN: r_byte = r_sel.green;
            default:    r_byte = r_sel.blue;
        endcase
        lk_rgb = (int'(lk_ent) < TOTAL) ? mem_q[int'(lk_ent)] : '0;
    end
endmodule

// File: rtl/clut_regs.sv
module clut_regs
    import clut_pkg::*;
#(
    parameter int MAIN_N = 256,
    parameter int OVL_N  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [3:0]                        reg_addr,
    input  logic [31:0]                       reg_wdata,
    output logic [31:0]                       reg_rdata,
    input  logic [$clog2(MAIN_N+OVL_N)-1:0]   lut_idx,
    output logic [3*COMP_W-1:0]               lut_rgb
);
    localparam int PTR_W = $clog2(MAIN_N);
    localparam int OVL_W = $clog2(OVL_N);
    localparam int ENT_W = $clog2(MAIN_N + OVL_N);

    logic             is_main, is_ovl, is_data, ptr_load, seq_step, tbl_we;
    logic [PTR_W-1:0] cur_ptr;
    step_e            cur_step;
    logic [ENT_W-1:0] sel_ent;
    logic [COMP_W-1:0] rd_byte;
    rgb_t             lk_val;

    assign is_main  = (reg_addr == OFS_MAIN);
    assign is_ovl   = (reg_addr == OFS_OVERLAY);
    assign is_data  = is_main || is_ovl;
    assign ptr_load = reg_wr && (reg_addr == OFS_POINTER);
    assign tbl_we   = reg_wr && is_data;
    assign seq_step = (reg_wr || reg_rd) && is_data;
    assign sel_ent  = is_ovl ? ENT_W'(MAIN_N) + ENT_W'(cur_ptr[OVL_W-1:0])
                             : ENT_W'(cur_ptr);

    clut_seq #(.PTR_W(PTR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (reg_wdata[31 -: PTR_W]),
        .step     (seq_step),
        .ptr      (cur_ptr),
        .comp     (cur_step)
    );

    clut_table #(.MAIN_N(MAIN_N), .OVL_N(OVL_N)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .w_ent  (sel_ent),
        .w_comp (cur_step),
        .w_byte (reg_wdata[31 -: COMP_W]),
        .r_ent  (sel_ent),
        .r_comp (cur_step),
        .r_byte (rd_byte),
        .lk_ent (lut_idx),
        .lk_rgb (lk_val)
    );

    assign reg_rdata = (reg_rd && !reg_wr && is_data) ? {rd_byte, {(32-COMP_W){1'b0}}} : 32'd0;
    assign lut_rgb   = lk_val;
endmodule

// File: rtl/clut_regs_chk.sv
module clut_regs_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [3:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic [PTR_W-1:0] ptr,
    input logic [1:0]       step
);
    logic data_acc, other_acc;
    assign data_acc  = (reg_wr || reg_rd) && (reg_addr == 4'h4 || reg_addr == 4'hC);
    assign other_acc = (reg_wr || reg_rd) && reg_addr != 4'h0 && reg_addr != 4'h4 && reg_addr != 4'hC;

    assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h0) |=> (ptr == $past(reg_wdata[31 -: PTR_W]) && step == 2'd0));

    assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step != 2'd3);

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && step == 2'd2) |=> (step == 2'd0 && ptr == PTR_W'($past(ptr) + 1'b1)));

    assert_rdata_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> reg_rdata[23:0] == 24'd0);

    assert_other_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        other_acc |=> ($stable(ptr) && $stable(step)));

    assert_other_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 4'h8) |-> reg_rdata == 32'd0);
endmodule

bind clut_regs clut_regs_chk #(.PTR_W($clog2(MAIN_N))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ptr       (cur_ptr),
    .step      (cur_step)
);

// File: tb/tb_clut_regs.sv
module tb_clut_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [8:0]  lut_idx = 9'd0;
    logic [23:0] lut_rgb;

    int compared = 0, mismatched = 0, cycles = 0;
    bit done = 0;

    // behavioural reference
    int m_red[260], m_grn[260], m_blu[260];
    int m_ptr, m_step;

    always #4 clk = ~clk;

    clut_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model_rgb(input int e);
        if (e > 259) return 24'd0;
        return {m_red[e][7:0], m_grn[e][7:0], m_blu[e][7:0]};
    endfunction

    function automatic int sel_entry(input logic [3:0] a);
        return (a == 4'hC) ? 256 + (m_ptr % 4) : m_ptr;
    endfunction

    // one clock: kind 0 idle, 1 write, 2 read
    task automatic op(input string req, input int kind, input logic [3:0] a,
                      input logic [31:0] d, input int probe);
        logic [31:0] exp_rd;
        int e, v;
        @(negedge clk);
        reg_wr = (kind == 1); reg_rd = (kind == 2);
        reg_addr = a; reg_wdata = d; lut_idx = 9'(probe);
        #1;
        exp_rd = 32'd0;
        if (kind == 2 && (a == 4'h4 || a == 4'hC)) begin
            e = sel_entry(a);
            v = (m_step == 0) ? m_red[e] : (m_step == 1) ? m_grn[e] : m_blu[e];
            exp_rd = {v[7:0], 24'd0};
        end
        check(req, reg_rdata, exp_rd);
        check({req, "/lookup R9"}, {8'd0, lut_rgb}, {8'd0, model_rgb(probe)});
        @(posedge clk); #1;
        if (kind == 1 && a == 4'h0) begin
            m_ptr = d[31:24]; m_step = 0;
        end else if (kind != 0 && (a == 4'h4 || a == 4'hC)) begin
            if (kind == 1) begin
                e = sel_entry(a);
                if (m_step == 0) m_red[e] = d[31:24];
                else if (m_step == 1) m_grn[e] = d[31:24];
                else m_blu[e] = d[31:24];
            end
            if (m_step == 2) begin m_step = 0; m_ptr = (m_ptr + 1) % 256; end
            else m_step++;
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                mismatched++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 260; i++) begin
            m_red[i] = (i == 255 || i == 256 || i == 258) ? 255 : 0;
            m_grn[i] = m_red[i]; m_blu[i] = m_red[i];
        end
        m_ptr = 0; m_step = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8: reset contents across every entry, plus out-of-range R9
        for (int i = 0; i < 260; i++) op("R8 reset entry", 0, 4'h0, 0, i);
        op("R9 out of range", 0, 4'h0, 0, 300);
        op("R9 out of range", 0, 4'h0, 0, 511);
        // R8/R5: first read after reset is red of entry 0
        op("R8 reset pointer R5", 2, 4'h4, 0, 0);
        op("R1 reload", 1, 4'h0, 32'h0A00_0000, 10);
        // R2: triplets into 10 and 11, R9 visible next cycle
        op("R2 red", 1, 4'h4, 32'h1100_0000, 10);
        op("R2 green", 1, 4'h4, 32'h22FF_FFFF, 10);
        op("R2 blue", 1, 4'h4, 32'h3300_0000, 10);
        op("R9 next cycle", 1, 4'h4, 32'h4400_0000, 10);
        op("R3 step", 1, 4'h4, 32'h5500_0000, 11);
        op("R3 step", 1, 4'h4, 32'h6600_0000, 11);
        // R5: read back entry 10 and 11
        op("R1 reload", 1, 4'h0, 32'h0A00_0000, 11);
        for (int i = 0; i < 6; i++) op("R5 read seq", 2, 4'h4, 0, 10 + i / 3);
        // R3: wrap 255 -> 0
        op("R1 reload", 1, 4'h0, 32'hFF00_0000, 255);
        op("R3 wrap", 1, 4'h4, 32'h0100_0000, 255);
        op("R3 wrap", 1, 4'h4, 32'h0200_0000, 255);
        op("R3 wrap", 1, 4'h4, 32'h0300_0000, 255);
        op("R3 after wrap", 2, 4'h4, 0, 0);
        // R1 mid-triplet reload
        op("R1 mid reload", 1, 4'h0, 32'h0500_0000, 5);
        op("R1 mid reload", 1, 4'h4, 32'h7700_0000, 5);
        // R4: overlay via pointer 6 -> entry 258, then 7 -> 259
        op("R1 reload", 1, 4'h0, 32'h0600_0000, 258);
        for (int i = 0; i < 6; i++) op("R4 overlay write", 1, 4'hC, 32'((i + 1) * 32'h1300_0000), 258 + i / 3);
        op("R4 overlay", 0, 4'h0, 0, 259);
        op("R1 reload", 1, 4'h0, 32'h0600_0000, 258);
        for (int i = 0; i < 3; i++) op("R4 R5 overlay read", 2, 4'hC, 0, 258);
        // R6: mixed reads and writes
        op("R1 reload", 1, 4'h0, 32'h1400_0000, 20);
        op("R6 mix", 1, 4'h4, 32'hA100_0000, 20);
        op("R6 mix", 2, 4'h4, 0, 20);
        op("R6 mix", 1, 4'h4, 32'hA300_0000, 20);
        op("R6 mix", 2, 4'h4, 0, 21);
        // R7: other offsets ignored
        op("R7 ignored", 1, 4'h8, 32'hDEAD_BEEF, 21);
        op("R7 ignored", 1, 4'h1, 32'h9900_0000, 21);
        op("R7 ignored", 2, 4'h8, 0, 21);
        op("R7 ignored", 2, 4'h0, 0, 21);
        op("R7 state kept", 2, 4'h4, 0, 21);
        op("R7 state kept", 2, 4'h4, 0, 21);
        op("R7 state kept", 2, 4'h4, 0, 22);
        for (int i = 0; i < 260; i += 7) op("R9 sweep", 0, 4'h0, 0, i);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule